// File: doc/BRIEF.md
# SMBus Register-Pointer Slave

This block is a serial-bus slave that gives a two-wire master access to a small register file through a single internal pointer. The block samples the open-drain clock and data lines with a fast system clock. It cleans up both lines, then detects start and stop conditions. It answers one 7-bit bus address. The upper six bits of that address are fixed. The low bit comes from a strap input that is captured while reset is held.

A write transaction carries one or two bytes after the address. The first byte always loads the pointer. The second byte, if it is sent, is written to the register the pointer selects. Any further byte is refused. A read transaction returns exactly one byte: the register at the stored pointer. The pointer never advances by itself. The block pulls the data line low for acknowledges and for zero bits of read data, and never drives it high. On the register side it presents the pointer as the register address. It gives a one-cycle write strobe with data, and it takes read data combinationally.

Top module: `smbus_ptr_slave`

## Requirements
- R1: The bus address is 7'h2C when `addr_sel` is low and 7'h2D when it is high. The level is captured while `rst_n` is low. Changes to `addr_sel` after reset have no effect until the next reset.
- R2: A rising SDA while SCL is high (stop) abandons the transaction from any state. A byte cut short by a stop causes no strobe and leaves the pointer unchanged.
- R3: On an address match the block pulls SDA low (`sda_oe`=1) through the ninth SCL pulse. On a mismatch it leaves `sda_oe` at 0 until the next start. `sda_oe` changes only while SCL is low.
- R4: The first byte of a write is acknowledged and loaded into the pointer, which `reg_addr` shows. A write with only this byte causes no strobe.
- R5: The second byte of a write is acknowledged. It causes one single-cycle `reg_we` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte.
- R6: Third and later write bytes are not acknowledged (SDA left high on the ninth clock) and cause no strobe.
- R7: A read returns `reg_rdata` at the pointer, MSB first. The data is sampled when the address byte is acknowledged. SDA is released in the master's acknowledge slot. The pointer is not incremented.
- R8: A repeated start begins a new transaction whose direction comes from its own address byte. A pointer set by a write before the repeated start is used by the read after it.
- R9: Pulses on SCL or SDA shorter than `FILT_LEN` system clocks are ignored.
- R10: After reset `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; also captures the strap |
| addr_sel | input | 1 | Strap that selects the low address bit |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | When 1, pull the data line low |
| reg_addr | output | 8 | Current pointer, used as the register address |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |

## Verification
The assertions check several properties on every cycle: the write strobe lasts exactly one cycle and coincides with the block's acknowledge, the pointer holds steady while read data is shifted out, a stop releases the data line, the strap stays fixed after reset, and the data drive moves only while the filtered clock is low. Other behaviours can only be shown by whole bus scenarios in the bench: address matching for each strap level, the count of acknowledged write bytes, the returned read byte, repeated-start pointer reuse, aborts by stop, and the rejection of short glitches.

// File: rtl/smbus_ptr_slave.sv
module smbus_ptr_slave #(
  parameter int       FILT_LEN  = 3,
  parameter bit [6:0] ADDR_BASE = 7'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} st_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic                scl_f, sda_f, scl_q, sda_q;
  logic                sel_q;
  st_t                 st;
  logic [3:0]          cnt;
  logic [7:0]          sh;
  logic [1:0]          phase;
  logic                rw, ack_q;
  logic [6:0]          my_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= addr_sel;
  end
  assign my_addr = {ADDR_BASE[6:1], sel_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire start_det = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; phase <= '0;
      rw <= 1'b0; ack_q <= 1'b0; reg_addr <= '0; reg_we <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_det) st <= S_IDLE;
      else if (start_det) begin
        st <= S_RX; cnt <= '0; phase <= '0;
      end else begin
        unique case (st)
          S_RX:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (phase == 2'd0) begin
                if (sh[7:1] == my_addr) begin
                  st <= S_ACK; ack_q <= 1'b1; rw <= sh[0]; sh <= reg_rdata;
                end else st <= S_IDLE;
              end else begin
                st    <= S_ACK;
                ack_q <= (phase != 2'd3);
                if (phase == 2'd1) reg_addr <= sh;
                if (phase == 2'd2) begin reg_we <= 1'b1; reg_wdata <= sh; end
              end
            end
          S_ACK:
            if (scl_fall) begin
              cnt <= '0;
              if (phase == 2'd0 && rw) st <= S_TX;
              else begin
                st <= S_RX;
                if (phase != 2'd3) phase <= phase + 2'd1;
              end
            end
          S_TX:
            if (scl_fall) begin
              if (cnt == 4'd7) st <= S_RACK;
              else begin sh <= {sh[6:0], 1'b0}; cnt <= cnt + 4'd1; end
            end
          S_RACK:
            if (scl_fall) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe = (st == S_ACK && ack_q) || (st == S_TX && !sh[7]);

  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_we_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sda_oe);
  p_ptr_hold_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |-> $stable(reg_addr));
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sel_q));
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

endmodule

// File: tb/smbus_ptr_slave_tb.sv
module smbus_ptr_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, addr_sel = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] regs [256];
  logic [15:0] exp_q [$];
  int checks = 0, errors = 0, oe_cnt = 0;
  bit done = 1'b0;

  wire sda_line = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  always #10 clk = ~clk;

  smbus_ptr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design strobes them
  always @(negedge clk) begin
    if (rst_n && sda_oe) oe_cnt++;
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected strobe", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R5 strobe addr/data", {reg_addr, reg_wdata}, e);
      end
      regs[reg_addr] = reg_wdata;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q);
    if (glitch) begin sda_m = ~b; tick(1); sda_m = b; tick(Q - 1); end
    else tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b0);
    recv_bit(nb);
    ack = !nb;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(1'b1, 1'b0);
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; addr_sel = sel; scl = 1'b1; sda_m = 1'b1;
    tick(5); rst_n = 1'b1; tick(5);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic a;
    logic [7:0] d;
    int oe0;
    for (int i = 0; i < 256; i++) regs[i] = 8'(i * 37 + 5);
    do_reset(1'b0);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R10 reset reg_we", reg_we, 0);
    chk(reg_addr == 8'h00, "R10 reset reg_addr", reg_addr, 0);

    // R1: strap change after reset ignored; R4 pointer-only write
    addr_sel = 1'b1;
    bus_start(); send_byte({7'h2C, 1'b0}, a);
    chk(a, "R1 address 2C acked with strap low", a, 1);
    send_byte(8'h12, a); chk(a, "R4 pointer byte acked", a, 1);
    bus_stop();
    chk(reg_addr == 8'h12, "R4 pointer loaded", reg_addr, 8'h12);

    // R3: mismatch is never driven
    oe0 = oe_cnt;
    bus_start(); send_byte({7'h2D, 1'b0}, a);
    chk(!a, "R3 address 2D not acked", a, 0);
    send_byte(8'h55, a); bus_stop();
    chk(oe_cnt == oe0, "R3 no drive after mismatch", oe_cnt - oe0, 0);

    // R5/R6: two-byte write then an extra byte
    bus_start(); send_byte({7'h2C, 1'b0}, a);
    send_byte(8'h30, a); chk(a, "R5 pointer acked", a, 1);
    exp_q.push_back({8'h30, 8'hA5});
    send_byte(8'hA5, a); chk(a, "R5 data acked", a, 1);
    send_byte(8'h77, a); chk(!a, "R6 third byte nacked", a, 0);
    bus_stop();
    chk(regs[8'h30] == 8'hA5 && exp_q.size() == 0, "R5 register written", regs[8'h30], 8'hA5);

    // R7: single-byte read, no auto-increment
    bus_start(); send_byte({7'h2C, 1'b1}, a); chk(a, "R7 read address acked", a, 1);
    recv_byte(d); bus_stop();
    chk(d == 8'hA5, "R7 read data", d, 8'hA5);
    chk(reg_addr == 8'h30, "R7 pointer not incremented", reg_addr, 8'h30);

    // R8: repeated start from write to read
    bus_start(); send_byte({7'h2C, 1'b0}, a); send_byte(8'h07, a);
    bus_start(); send_byte({7'h2C, 1'b1}, a); chk(a, "R8 read after repeated start acked", a, 1);
    recv_byte(d); bus_stop();
    chk(d == regs[7], "R8 read at pointer set before repeated start", d, regs[7]);

    // R2: stop in the middle of the pointer byte, then in the data byte
    bus_start(); send_byte({7'h2C, 1'b0}, a);
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    bus_stop();
    chk(reg_addr == 8'h07, "R2 pointer unchanged by aborted byte", reg_addr, 8'h07);
    bus_start(); send_byte({7'h2C, 1'b0}, a); send_byte(8'h44, a);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    bus_stop(); tick(Q);
    chk(exp_q.size() == 0 && regs[8'h44] == 8'(8'h44 * 37 + 5), "R2 no strobe after abort",
        regs[8'h44], 8'(8'h44 * 37 + 5));

    // R9: glitches on SDA (while SCL high) and on SCL (while low)
    bus_start(); send_byte({7'h2C, 1'b0}, a); send_byte(8'h50, a);
    exp_q.push_back({8'h50, 8'h81});
    send_bit(1'b1, 1'b1);
    scl = 1'b1; tick(1); scl = 1'b0; tick(2);
    for (int i = 6; i >= 0; i--) send_bit(i == 0, 1'b0);
    recv_bit(a); chk(!a, "R9 data acked despite glitches", a, 0);
    bus_stop();
    chk(regs[8'h50] == 8'h81, "R9 glitches ignored", regs[8'h50], 8'h81);

    // R1: strap high at reset
    do_reset(1'b1);
    bus_start(); send_byte({7'h2D, 1'b0}, a); bus_stop();
    chk(a, "R1 address 2D acked with strap high", a, 1);
    bus_start(); send_byte({7'h2C, 1'b0}, a); bus_stop();
    chk(!a, "R1 address 2C refused with strap high", a, 0);

    tick(10);
    chk(exp_q.size() == 0, "R5 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule